// File: doc/BRIEF.md
# Lock-Detect Glitch Mask Filter

This block sits after the lock decision of a speed-control loop. It takes a raw, active-low lock indication and produces a filtered lock output with the same polarity: low means locked and high means unlocked. The filter is deliberately one-sided. It removes short excursions of only one polarity, and a select input chooses which one. Changes of the other polarity reach the output on the next clock.

With the select input high, brief lock indications are hidden. This suits pull-in, where the loop hunts around the target. In this setting a real lock shows at the output only after the raw signal has stayed low for the whole mask time. With the select input low, brief unlock indications are hidden, so a locked motor does not report short dropouts. The mask time is a count of clock samples. A count of zero turns masking off, and the output then follows the raw signal one cycle later.

Top module: `lock_glitch_mask`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `lock_n` is 1 (unlocked).
- R2: When `hold_ticks` is 0, `lock_n` equals the `lock_raw_n` value sampled at the previous rising clock edge, for both polarities and either `mask_pol` value.
- R3: With `mask_pol` = 1 and `hold_ticks` = N > 0, a change of `lock_raw_n` from 1 to 0 reaches `lock_n` at the edge that takes the N-th consecutive 0 sample. For N = 1 this is the first sample.
- R4: With `mask_pol` = 1, a 0 pulse on `lock_raw_n` that lasts fewer than N samples never reaches `lock_n`.
- R5: With `mask_pol` = 0, a change from 0 to 1 needs N consecutive 1 samples. A 1 pulse shorter than N samples never reaches `lock_n`.
- R6: A change toward the unmasked level reaches `lock_n` at the edge that samples it. That is 0 to 1 when `mask_pol` = 1, and 1 to 0 when `mask_pol` = 0.
- R7: Any sample at which `lock_raw_n` equals `lock_n` restarts the count from zero. Separate short pulses never add up to an accepted change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lock_raw_n | input | 1 | Raw lock indication, 0 = locked |
| mask_pol | input | 1 | 1: hide short lock pulses; 0: hide short unlock pulses |
| hold_ticks | input | CNT_W | Mask time in clock samples; 0 disables masking |
| lock_n | output | 1 | Filtered lock indication, 0 = locked |

## Verification
The bench places pulses exactly one sample shorter than the mask time and checks that they never show. A design that compares the count off by one would let them through, or would accept a real change one cycle late. It sends two short pulses with a single-sample gap between them and checks that neither is accepted. A design that did not restart its count would accept the second pulse. It also covers a mask time of 1, the edge at which a long 20-sample hold is accepted, reset in the middle of a run, and pass-through mode, where a design that kept counting would delay or drop changes.

// File: rtl/lmf_pkg.sv
package lmf_pkg;

    // Which raw level is held back until it has been stable for the mask time
    typedef enum logic {
        HIDE_UNLOCK_PULSES = 1'b0,   // raw high (unlock) is delayed
        HIDE_LOCK_PULSES   = 1'b1    // raw low (lock) is delayed
    } mask_pol_e;

    typedef struct packed {
        logic lock_n;
    } filt_state_t;

endpackage

// File: rtl/lmf_classify.sv
module lmf_classify (
    input  logic lock_raw_n,
    input  logic lock_n_cur,
    input  logic mask_pol,
    output logic differ,
    output logic masked
);
    import lmf_pkg::*;

    mask_pol_e pol;

    always_comb begin
        pol    = mask_pol_e'(mask_pol);
        differ = (lock_raw_n != lock_n_cur);
        // The held-back level is the one opposite to the polarity code
        masked = differ && (lock_raw_n != logic'(pol));
    end

endmodule

// File: rtl/lmf_hold_timer.sv
module lmf_hold_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    localparam int SUM_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t       tmr_d, tmr_q;
    logic [SUM_W-1:0] next_cnt;

    always_comb begin
        tmr_d    = tmr_q;
        next_cnt = {1'b0, tmr_q.cnt} + SUM_W'(1);
        expire   = run && (next_cnt >= {1'b0, limit});
        if (run && !expire) begin
            tmr_d.cnt = next_cnt[CNT_W-1:0];
        end else begin
            tmr_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R7
    restart_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$past(run) && (limit > CNT_W'(1))) |-> !expire);

endmodule

// File: rtl/lock_glitch_mask.sv
module lock_glitch_mask #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_raw_n,
    input  logic             mask_pol,
    input  logic [CNT_W-1:0] hold_ticks,
    output logic             lock_n
);
    import lmf_pkg::*;

    filt_state_t state_d, state_q;
    logic        filt_en;
    logic        differ;
    logic        masked;
    logic        expire;

    assign filt_en = |hold_ticks;

    lmf_classify u_classify (
        .lock_raw_n (lock_raw_n),
        .lock_n_cur (state_q.lock_n),
        .mask_pol   (mask_pol),
        .differ     (differ),
        .masked     (masked)
    );

    lmf_hold_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (filt_en && masked),
        .limit  (hold_ticks),
        .expire (expire)
    );

    always_comb begin
        state_d = state_q;
        if (!filt_en) begin
            state_d.lock_n = lock_raw_n;
        end else if (differ && (!masked || expire)) begin
            state_d.lock_n = lock_raw_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.lock_n <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign lock_n = state_q.lock_n;

    // R1
    reset_unlocked_chk: assert property (@(posedge clk)
        !rst_n |=> lock_n);

    // R2
    passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ticks == '0) |=> (lock_n == $past(lock_raw_n)));

    // R6
    unmasked_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && (lock_raw_n != lock_n) && (lock_raw_n == mask_pol))
        |=> (lock_n == $past(lock_raw_n)));

    // R3
    only_raw_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_n) |-> (lock_n == $past(lock_raw_n)));

endmodule

// File: tb/test_lock_glitch_mask.sv
module test_lock_glitch_mask;

    localparam int CNT_W = 24;
    localparam int NVEC  = 26;

    // {req[3:0], mask_pol, ticks[6:0], raw, exp, 2'b00}
    localparam logic [15:0] VEC [NVEC] = '{
        {4'd3, 1'b1, 7'd3, 1'b1, 1'b1, 2'b00},  // idle unlocked
        {4'd3, 1'b1, 7'd3, 1'b0, 1'b1, 2'b00},  // R3 sample 1
        {4'd3, 1'b1, 7'd3, 1'b0, 1'b1, 2'b00},  // R3 sample 2
        {4'd3, 1'b1, 7'd3, 1'b0, 1'b0, 2'b00},  // R3 sample 3 accepted
        {4'd6, 1'b1, 7'd3, 1'b1, 1'b1, 2'b00},  // R6 unlock immediate
        {4'd4, 1'b1, 7'd3, 1'b0, 1'b1, 2'b00},  // R4
        {4'd4, 1'b1, 7'd3, 1'b0, 1'b1, 2'b00},  // R4
        {4'd4, 1'b1, 7'd3, 1'b1, 1'b1, 2'b00},  // R4 two-sample pulse hidden
        {4'd7, 1'b1, 7'd3, 1'b0, 1'b1, 2'b00},  // R7
        {4'd7, 1'b1, 7'd3, 1'b1, 1'b1, 2'b00},  // R7 gap
        {4'd7, 1'b1, 7'd3, 1'b0, 1'b1, 2'b00},  // R7
        {4'd7, 1'b1, 7'd3, 1'b0, 1'b1, 2'b00},  // R7 restarted, not accepted
        {4'd7, 1'b1, 7'd3, 1'b1, 1'b1, 2'b00},  // R7
        {4'd6, 1'b0, 7'd3, 1'b0, 1'b0, 2'b00},  // R6 lock immediate
        {4'd5, 1'b0, 7'd3, 1'b1, 1'b0, 2'b00},  // R5
        {4'd5, 1'b0, 7'd3, 1'b1, 1'b0, 2'b00},  // R5
        {4'd5, 1'b0, 7'd3, 1'b0, 1'b0, 2'b00},  // R5 short unlock hidden
        {4'd5, 1'b0, 7'd3, 1'b1, 1'b0, 2'b00},  // R5
        {4'd5, 1'b0, 7'd3, 1'b1, 1'b0, 2'b00},  // R5
        {4'd5, 1'b0, 7'd3, 1'b1, 1'b1, 2'b00},  // R5 unlock accepted
        {4'd6, 1'b0, 7'd3, 1'b0, 1'b0, 2'b00},  // R6
        {4'd2, 1'b1, 7'd0, 1'b1, 1'b1, 2'b00},  // R2 pass-through
        {4'd2, 1'b1, 7'd0, 1'b0, 1'b0, 2'b00},  // R2
        {4'd2, 1'b1, 7'd0, 1'b1, 1'b1, 2'b00},  // R2
        {4'd2, 1'b0, 7'd0, 1'b0, 1'b0, 2'b00},  // R2
        {4'd2, 1'b0, 7'd0, 1'b1, 1'b1, 2'b00}   // R2
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lock_raw_n = 1'b1;
    logic             mask_pol = 1'b1;
    logic [CNT_W-1:0] hold_ticks = '0;
    logic             lock_n;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    lock_glitch_mask #(.CNT_W(CNT_W)) i_lock_glitch_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_raw_n (lock_raw_n),
        .mask_pol   (mask_pol),
        .hold_ticks (hold_ticks),
        .lock_n     (lock_n)
    );

    task automatic check(input string req, input logic exp);
        n_checks++;
        if (lock_n !== exp) begin
            n_fails++;
            $display("FAIL %s: lock_n=%b expected %b at %0t", req, lock_n, exp, $time);
        end
    endtask

    // drive one raw sample, then wait past the edge that takes it
    task automatic step(input logic raw);
        lock_raw_n = raw;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1", 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b1);

        for (int i = 0; i < NVEC; i++) begin
            mask_pol   = VEC[i][11];
            hold_ticks = CNT_W'(VEC[i][10:4]);
            step(VEC[i][3]);
            check($sformatf("R%0d", VEC[i][15:12]), VEC[i][2]);
        end

        // R3 boundary: mask time of one sample
        mask_pol   = 1'b1;
        hold_ticks = CNT_W'(1);
        step(1'b1);
        check("R6", 1'b1);
        step(1'b0);
        check("R3", 1'b0);

        // R3 / R4: long hold of 20 samples
        step(1'b1);
        hold_ticks = CNT_W'(20);
        for (int k = 1; k < 20; k++) begin
            step(1'b0);
            if (k == 19) check("R4", 1'b1);
        end
        step(1'b0);
        check("R3", 1'b0);

        // R1: reset in the middle of a locked run
        rst_n = 1'b0;
        #1;
        check("R1", 1'b1);
        @(negedge clk);
        check("R1", 1'b1);
        rst_n = 1'b1;
        step(1'b0);
        check("R4", 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule